// File: doc/BRIEF.md
# SDRAM Bank Interruption Tracker

This block sits beside the command issue logic of a single-data-rate SDRAM controller. It watches the command stream as the memory registers it, one command per clock. Each command carries a four-bit code, a bank number and an auto-precharge flag. From that stream the block keeps the state of each of four banks. It raises a same-cycle flag on any command that the current bank states do not permit. It also reports which cycles carry read or write data and how far ahead of a WRITE the data mask must go up.

The main purpose is to follow bursts cut short by a READ or WRITE to another bank. When the cut burst had auto precharge, that bank closes itself while the new burst runs. A cut read begins precharge in the same cycle the new command is registered. A cut write first waits out the write-recovery time. The scheduler reads the bank states to decide which commands it may issue next. It reads the data-valid strobes to steer the data path.

CAS latency (2 or 3), write recovery and row precharge come in as cycle counts on configuration inputs. The burst length is a parameter.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every bank reports IDLE, and `rd_valid_o`, `wr_valid_o`, `dqm_lead_o` and `illegal_o` are all 0.
- R2: Bank state codes are IDLE 0, ACTIVE 1, READING 2, WRITING 3, RECOVERING 4, PRECHARGING 5, reported for bank i in `bank_state_o[3i+2:3i]`. A legal ACTIVATE makes its bank ACTIVE on the next cycle. A legal READ or WRITE keeps its bank READING or WRITING for BL cycles. The bank then becomes ACTIVE. With auto precharge it instead becomes PRECHARGING after a read, or RECOVERING after a write.
- R3: `rd_valid_o` is high exactly CL cycles after each cycle in which some bank is READING. CL is 3 when `cl3_i` is 1 and 2 otherwise. `rd_bank_o` then names that bank.
- R4: A legal READ to bank m while bank n is READING takes bank n out of READING on the next cycle. The data beats of n and then m leave back to back on `rd_valid_o`, with `rd_bank_o` switching from n to m.
- R5: A read burst with auto precharge that is cut by a legal READ or WRITE to another bank shows PRECHARGING on the next cycle. It stays there for tRP cycles and then goes IDLE.
- R6: A write burst with auto precharge that is cut by a legal READ or WRITE to another bank shows RECOVERING for tWR cycles, then PRECHARGING for tRP cycles, then IDLE. A `twr_i` or `trp_i` value of 0 counts as 1. The value is sampled when the timed state is entered.
- R7: `wr_valid_o` is high, with `wr_bank_o` naming the bank, in each cycle a bank is WRITING. For a cut write, the last such cycle is the one before the interrupting command takes effect.
- R8: `dqm_lead_o` gives the mask lead, in clocks, that a WRITE issued now would need. It is 0 when no bank is READING, 1 when the reading bank has no auto precharge, and 2 when it has auto precharge.
- R9: AUTO REFRESH (6), SELF REFRESH (7) and LOAD MODE (8) are legal only when all four banks are IDLE.
- R10: BURST STOP (5) is legal only when its bank field names the bank that is bursting without auto precharge. It returns that bank to ACTIVE. At most one bank is READING or WRITING at any time.
- R11: Command codes are NOP 0, ACTIVATE 1, READ 2, WRITE 3, PRECHARGE 4, BURST STOP 5, AUTO REFRESH 6, SELF REFRESH 7 and LOAD MODE 8. The following are illegal: codes 9 to 15, ACTIVATE to a non-idle bank, READ or WRITE to a bank that is neither ACTIVE nor bursting without auto precharge, and PRECHARGE to a bank with auto precharge pending or in RECOVERING or PRECHARGING.
- R12: `illegal_o` is high in the same cycle as an offending command. That command changes no bank state.
- R13: A legal PRECHARGE to a non-idle bank makes it PRECHARGING for tRP cycles and then IDLE. A PRECHARGE to an IDLE bank is legal and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 4 | Registered command code |
| bank_i | input | 2 | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge flag of a READ or WRITE |
| cl3_i | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| twr_i | input | 3 | Write recovery in cycles |
| trp_i | input | 3 | Row precharge in cycles |
| bank_state_o | output | 12 | Three-bit state per bank, bank 0 lowest |
| rd_valid_o | output | 1 | Read data beat on the bus this cycle |
| rd_bank_o | output | 2 | Bank of that read beat |
| wr_valid_o | output | 1 | Write data beat registered for a bank |
| wr_bank_o | output | 2 | Bank of that write beat |
| dqm_lead_o | output | 2 | Mask lead needed before a WRITE |
| illegal_o | output | 1 | Current command is not permitted |

## Verification
The bench goes after bursts cut by another bank in all four read/write pairings, with and without auto precharge. A design that starts the precharge of a cut write at once, instead of after tWR, shows PRECHARGING one phase early. One that leaves the cut bank bursting breaks the single-burst rule and the write-beat ownership. Illegal commands are aimed at busy banks, at banks with auto precharge pending, and at refresh while any bank is open. A tracker that lets such a command through would open or close banks that the scheduler believes untouched. The read strobe is followed across CAS latency changes and back-to-back read handovers, where an off-by-one delay would hand data to the wrong bank.

// File: rtl/sdram_bt_pkg.sv
package sdram_bt_pkg;

    localparam int TMR_W = 3;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_ACT  = 4'd1,
        C_RD   = 4'd2,
        C_WR   = 4'd3,
        C_PRE  = 4'd4,
        C_BST  = 4'd5,
        C_AREF = 4'd6,
        C_SREF = 4'd7,
        C_LMR  = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ACTIVE = 3'd1,
        S_READ   = 3'd2,
        S_WRITE  = 3'd3,
        S_RECOV  = 3'd4,
        S_PRECH  = 3'd5
    } bstate_e;

    // per-bank control produced by the decoder for one cycle
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic ap;
        logic pre;
        logic cut;
    } bank_ctl_t;

    function automatic logic is_burst(bstate_e s);
        return (s == S_READ) || (s == S_WRITE);
    endfunction

    function automatic logic [TMR_W-1:0] at_least1(logic [TMR_W-1:0] v);
        return (v == '0) ? TMR_W'(1) : v;
    endfunction

endpackage

// File: rtl/sdram_bt_bank.sv
module sdram_bt_bank
    import sdram_bt_pkg::*;
#(
    parameter int BL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_ctl_t        ctl_i,
    input  logic [TMR_W-1:0] twr_i,
    input  logic [TMR_W-1:0] trp_i,
    output bstate_e          state_o,
    output logic             ap_o
);
    localparam int CW = (BL > 2) ? $clog2(BL) : 1;

    bstate_e          st;
    logic             ap;
    logic [CW-1:0]    beats;
    logic [TMR_W-1:0] tmr;

    bstate_e          end_st;
    logic [TMR_W-1:0] end_tmr;

    // where a burst goes when it ends, by itself or cut short
    always_comb begin
        end_st  = S_ACTIVE;
        end_tmr = tmr;
        if (ap) begin
            if (st == S_READ) begin
                end_st  = S_PRECH;
                end_tmr = at_least1(trp_i);
            end else begin
                end_st  = S_RECOV;
                end_tmr = at_least1(twr_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            ap    <= 1'b0;
            beats <= '0;
            tmr   <= '0;
        end else if (ctl_i.act) begin
            st <= S_ACTIVE;
            ap <= 1'b0;
        end else if (ctl_i.rd || ctl_i.wr) begin
            st    <= ctl_i.rd ? S_READ : S_WRITE;
            ap    <= ctl_i.ap;
            beats <= CW'(BL - 1);
        end else if (ctl_i.pre) begin
            st  <= S_PRECH;
            ap  <= 1'b0;
            tmr <= at_least1(trp_i);
        end else if (ctl_i.cut) begin
            st  <= end_st;
            tmr <= end_tmr;
        end else begin
            case (st)
                S_READ, S_WRITE: begin
                    if (beats == '0) begin
                        st  <= end_st;
                        tmr <= end_tmr;
                    end else begin
                        beats <= beats - 1'b1;
                    end
                end
                S_RECOV: begin
                    if (tmr <= TMR_W'(1)) begin
                        st  <= S_PRECH;
                        tmr <= at_least1(trp_i);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                S_PRECH: begin
                    if (tmr <= TMR_W'(1)) begin
                        st <= S_IDLE;
                        ap <= 1'b0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o = st;
    assign ap_o    = ap;

endmodule

// File: rtl/sdram_bt_decode.sv
module sdram_bt_decode
    import sdram_bt_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic [3:0]       cmd_i,
    input  logic [BW-1:0]    bank_i,
    input  logic             ap_i,
    input  bstate_e          st_i [NBANK],
    input  logic [NBANK-1:0] ap_flags_i,
    output bank_ctl_t        ctl_o [NBANK],
    output logic             illegal_o
);
    logic          all_idle;
    logic          any_burst;
    logic          burst_ap;
    logic [BW-1:0] burst_bank;
    bstate_e       tgt;
    logic          tgt_ap;
    logic          legal;
    logic          is_rw;

    always_comb begin
        all_idle   = 1'b1;
        any_burst  = 1'b0;
        burst_ap   = 1'b0;
        burst_bank = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (st_i[i] != S_IDLE) all_idle = 1'b0;
            if (is_burst(st_i[i])) begin
                any_burst  = 1'b1;
                burst_ap   = ap_flags_i[i];
                burst_bank = BW'(i);
            end
        end
        tgt    = st_i[bank_i];
        tgt_ap = ap_flags_i[bank_i];
        is_rw  = (cmd_i == C_RD) || (cmd_i == C_WR);

        case (cmd_i)
            C_NOP:             legal = 1'b1;
            C_ACT:             legal = (tgt == S_IDLE);
            C_RD, C_WR:        legal = (tgt == S_ACTIVE) || (is_burst(tgt) && !tgt_ap);
            C_PRE:             legal = (tgt == S_IDLE) || (tgt == S_ACTIVE)
                                       || (is_burst(tgt) && !tgt_ap);
            C_BST:             legal = any_burst && !burst_ap && (burst_bank == bank_i);
            C_AREF, C_SREF,
            C_LMR:             legal = all_idle;
            default:           legal = 1'b0;
        endcase
        illegal_o = !legal;

        for (int i = 0; i < NBANK; i++) begin
            ctl_o[i] = '0;
            if (legal && (bank_i == BW'(i))) begin
                ctl_o[i].act = (cmd_i == C_ACT);
                ctl_o[i].rd  = (cmd_i == C_RD);
                ctl_o[i].wr  = (cmd_i == C_WR);
                ctl_o[i].ap  = is_rw && ap_i;
                ctl_o[i].pre = (cmd_i == C_PRE) && (tgt != S_IDLE);
                ctl_o[i].cut = (cmd_i == C_BST);
            end
            // a new burst elsewhere cuts the running one
            if (legal && is_rw && (bank_i != BW'(i)) && is_burst(st_i[i])) begin
                ctl_o[i].cut = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdram_bt_rdpipe.sv
module sdram_bt_rdpipe #(
    parameter int BW    = 2,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_v,
    input  logic [BW-1:0] in_b,
    input  logic          long_i,
    output logic          out_v,
    output logic [BW-1:0] out_b
);
    logic [DEPTH-1:0] v;
    logic [BW-1:0]    b [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            v <= '0;
            for (int k = 0; k < DEPTH; k++) b[k] <= '0;
        end else begin
            v    <= {v[DEPTH-2:0], in_v};
            b[0] <= in_b;
            for (int k = 1; k < DEPTH; k++) b[k] <= b[k-1];
        end
    end

    assign out_v = long_i ? v[DEPTH-1] : v[DEPTH-2];
    assign out_b = long_i ? b[DEPTH-1] : b[DEPTH-2];

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_bt_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BL    = 4,
    localparam int BW   = $clog2(NBANK),
    localparam int SW   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         cmd_i,
    input  logic [BW-1:0]      bank_i,
    input  logic               ap_i,
    input  logic               cl3_i,
    input  logic [TMR_W-1:0]   twr_i,
    input  logic [TMR_W-1:0]   trp_i,
    output logic [NBANK*SW-1:0] bank_state_o,
    output logic               rd_valid_o,
    output logic [BW-1:0]      rd_bank_o,
    output logic               wr_valid_o,
    output logic [BW-1:0]      wr_bank_o,
    output logic [1:0]         dqm_lead_o,
    output logic               illegal_o
);
    localparam int CL_MAX = 3;

    bstate_e          bank_st [NBANK];
    logic [NBANK-1:0] bank_ap;
    bank_ctl_t        bank_ctl [NBANK];

    logic          rd_any, wr_any, rd_ap;
    logic [BW-1:0] rd_bk, wr_bk;

    sdram_bt_decode #(.NBANK(NBANK)) u_decode (
        .cmd_i      (cmd_i),
        .bank_i     (bank_i),
        .ap_i       (ap_i),
        .st_i       (bank_st),
        .ap_flags_i (bank_ap),
        .ctl_o      (bank_ctl),
        .illegal_o  (illegal_o)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_bt_bank #(.BL(BL)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .ctl_i   (bank_ctl[g]),
            .twr_i   (twr_i),
            .trp_i   (trp_i),
            .state_o (bank_st[g]),
            .ap_o    (bank_ap[g])
        );
        assign bank_state_o[g*SW +: SW] = bank_st[g];
    end

    always_comb begin
        rd_any = 1'b0;
        rd_bk  = '0;
        rd_ap  = 1'b0;
        wr_any = 1'b0;
        wr_bk  = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (bank_st[i] == S_READ) begin
                rd_any = 1'b1;
                rd_bk  = BW'(i);
                rd_ap  = bank_ap[i];
            end
            if (bank_st[i] == S_WRITE) begin
                wr_any = 1'b1;
                wr_bk  = BW'(i);
            end
        end
    end

    assign wr_valid_o = wr_any;
    assign wr_bank_o  = wr_bk;
    assign dqm_lead_o = !rd_any ? 2'd0 : (rd_ap ? 2'd2 : 2'd1);

    sdram_bt_rdpipe #(.BW(BW), .DEPTH(CL_MAX)) u_rdpipe (
        .clk    (clk),
        .rst    (rst),
        .in_v   (rd_any),
        .in_b   (rd_bk),
        .long_i (cl3_i),
        .out_v  (rd_valid_o),
        .out_b  (rd_bank_o)
    );

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk
    import sdram_bt_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BW   = $clog2(NBANK)
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         cmd_i,
    input logic [BW-1:0]      bank_i,
    input logic               illegal_o,
    input logic [NBANK*3-1:0] bank_state_o,
    input logic               rd_valid_o,
    input logic [1:0]         dqm_lead_o,
    input logic [NBANK-1:0]   bank_ap
);
    logic [2:0]       st [NBANK];
    logic [NBANK-1:0] bursting;
    logic             any_rd, all_idle, rw_cmd;

    always_comb begin
        any_rd   = 1'b0;
        all_idle = 1'b1;
        for (int i = 0; i < NBANK; i++) begin
            st[i]       = bank_state_o[i*3 +: 3];
            bursting[i] = (st[i] == 3'd2) || (st[i] == 3'd3);
            if (st[i] == 3'd2) any_rd = 1'b1;
            if (st[i] != 3'd0) all_idle = 1'b0;
        end
        rw_cmd = !illegal_o && ((cmd_i == C_RD) || (cmd_i == C_WR));
    end

    a_r10_single_burst: assert property (@(posedge clk) disable iff (rst)
        $countones(bursting) <= 1);

    a_r12_illegal_keeps_idle: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && all_idle) |=> all_idle);

    a_r8_dqm_needs_read: assert property (@(posedge clk) disable iff (rst)
        (dqm_lead_o != 2'd0) |-> any_rd);

    a_r3_rd_origin: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ($past(any_rd, 2) || $past(any_rd, 3)));

    for (genvar g = 0; g < NBANK; g++) begin : g_chk
        a_r5_read_ap_cut: assert property (@(posedge clk) disable iff (rst)
            (st[g] == 3'd2 && bank_ap[g] && rw_cmd && bank_i != BW'(g)) |=> st[g] == 3'd5);

        a_r6_write_ap_cut: assert property (@(posedge clk) disable iff (rst)
            (st[g] == 3'd3 && bank_ap[g] && rw_cmd && bank_i != BW'(g)) |=> st[g] == 3'd4);

        a_r13_idle_via_prech: assert property (@(posedge clk) disable iff (rst)
            (st[g] == 3'd0 && $past(st[g]) != 3'd0) |-> $past(st[g]) == 3'd5);
    end

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(.NBANK(NBANK)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_i        (cmd_i),
    .bank_i       (bank_i),
    .illegal_o    (illegal_o),
    .bank_state_o (bank_state_o),
    .rd_valid_o   (rd_valid_o),
    .dqm_lead_o   (dqm_lead_o),
    .bank_ap      (bank_ap)
);

// File: tb/test_sdram_bank_tracker.sv
module test_sdram_bank_tracker;

    localparam int NB = 4;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd_i = 4'd0;
    logic [1:0]  bank_i = 2'd0;
    logic        ap_i = 1'b0;
    logic        cl3_i = 1'b0;
    logic [2:0]  twr_i = 3'd2;
    logic [2:0]  trp_i = 3'd3;
    logic [11:0] bank_state_o;
    logic        rd_valid_o, wr_valid_o, illegal_o;
    logic [1:0]  rd_bank_o, wr_bank_o, dqm_lead_o;

    sdram_bank_tracker #(.NBANK(NB), .BL(BL)) i_sdram_bank_tracker (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
        .cl3_i(cl3_i), .twr_i(twr_i), .trp_i(trp_i),
        .bank_state_o(bank_state_o), .rd_valid_o(rd_valid_o), .rd_bank_o(rd_bank_o),
        .wr_valid_o(wr_valid_o), .wr_bank_o(wr_bank_o), .dqm_lead_o(dqm_lead_o),
        .illegal_o(illegal_o)
    );

    always #5 clk = ~clk;

    int vecs = 0;
    int bad  = 0;
    bit done = 1'b0;
    bit last_ill;

    // reference model: state, auto-precharge, elapsed cycles, phase length
    int mst [NB];
    int map [NB];
    int mcnt [NB];
    int mlen [NB];
    int rdq [$];

    task automatic check(string tag, int got, int exp);
        vecs++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int clamp1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int dut_st(int i);
        return int'(bank_state_o[i*3 +: 3]);
    endfunction

    function automatic bit m_legal(int c, int b);
        bit idle = 1'b1;
        int bb = -1;
        for (int i = 0; i < NB; i++) begin
            if (mst[i] != 0) idle = 1'b0;
            if (mst[i] == 2 || mst[i] == 3) bb = i;
        end
        case (c)
            0: return 1'b1;
            1: return mst[b] == 0;
            2, 3: return mst[b] == 1 || ((mst[b] == 2 || mst[b] == 3) && map[b] == 0);
            4: return mst[b] <= 1 || ((mst[b] == 2 || mst[b] == 3) && map[b] == 0);
            5: return bb == b && map[b] == 0;
            6, 7, 8: return idle;
            default: return 1'b0;
        endcase
    endfunction

    task automatic m_finish(int i);
        mcnt[i] = 1;
        if (map[i] == 0) mst[i] = 1;
        else if (mst[i] == 2) begin mst[i] = 5; mlen[i] = clamp1(int'(trp_i)); end
        else begin mst[i] = 4; mlen[i] = clamp1(int'(twr_i)); end
    endtask

    task automatic m_step(int c, int b, int a, bit lg);
        int rv = 0;
        for (int i = 0; i < NB; i++) begin
            bit hit = lg && (b == i);
            bit busy = (mst[i] == 2 || mst[i] == 3);
            if (hit && c == 1) begin
                mst[i] = 1; map[i] = 0;
            end else if (hit && (c == 2 || c == 3)) begin
                mst[i] = c; map[i] = a; mcnt[i] = 1; mlen[i] = BL;
            end else if (hit && c == 4) begin
                if (mst[i] != 0) begin
                    mst[i] = 5; map[i] = 0; mcnt[i] = 1; mlen[i] = clamp1(int'(trp_i));
                end
            end else if (hit && c == 5) begin
                m_finish(i);
            end else if (lg && (c == 2 || c == 3) && busy) begin
                m_finish(i);
            end else if (mst[i] >= 2) begin
                if (mcnt[i] < mlen[i]) mcnt[i]++;
                else if (busy) m_finish(i);
                else if (mst[i] == 4) begin
                    mst[i] = 5; mcnt[i] = 1; mlen[i] = clamp1(int'(trp_i));
                end else begin
                    mst[i] = 0; map[i] = 0;
                end
            end
        end
        for (int i = 0; i < NB; i++) if (mst[i] == 2) rv = 8 + i;
        rdq.push_back(rv);
    endtask

    task automatic compare_all();
        int exp_rd, wv, wb, lead;
        wv = 0; wb = 0; lead = 0;
        for (int i = 0; i < NB; i++) begin
            check("R2 bank state", dut_st(i), mst[i]);
            if (mst[i] == 3) begin wv = 1; wb = i; end
            if (mst[i] == 2) lead = map[i] ? 2 : 1;
        end
        exp_rd = rdq[rdq.size() - 1 - (cl3_i ? 3 : 2)];
        check("R3 rd_valid", int'(rd_valid_o), exp_rd >> 3);
        if (exp_rd != 0) check("R4 rd_bank", int'(rd_bank_o), exp_rd & 3);
        check("R7 wr_valid", int'(wr_valid_o), wv);
        if (wv != 0) check("R7 wr_bank", int'(wr_bank_o), wb);
        check("R8 dqm_lead", int'(dqm_lead_o), lead);
    endtask

    // drive at negedge, check the flag, let one edge pass, compare
    task automatic step(int c, int b = 0, int a = 0);
        bit lg;
        cmd_i  = 4'(c);
        bank_i = 2'(b);
        ap_i   = a[0];
        #1;
        lg = m_legal(c, b);
        last_ill = illegal_o;
        check("R12 illegal", int'(illegal_o), lg ? 0 : 1);
        m_step(c, b, a, lg);
        @(negedge clk);
        compare_all();
    endtask

    task automatic nops(int n);
        for (int k = 0; k < n; k++) step(0);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            mst[i] = 0; map[i] = 0; mcnt[i] = 0; mlen[i] = 1;
        end
        for (int k = 0; k < 4; k++) rdq.push_back(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 states", int'(bank_state_o), 0);
        check("R1 rd_valid", int'(rd_valid_o), 0);
        check("R1 wr_valid", int'(wr_valid_o), 0);
        check("R1 dqm", int'(dqm_lead_o), 0);
        #1 check("R1 illegal", int'(illegal_o), 0);
        @(negedge clk);

        step(1, 0); step(1, 1);
        check("R2 bank1 active", dut_st(1), 1);
        step(2, 0, 1);
        check("R8 lead with ap", int'(dqm_lead_o), 2);
        step(0);
        step(2, 1, 0);
        check("R5 cut read ap", dut_st(0), 5);
        check("R8 lead no ap", int'(dqm_lead_o), 1);
        step(3, 0);
        check("R11 rw to precharging", int'(last_ill), 1);
        nops(8);
        check("R5 back to idle", dut_st(0), 0);
        step(6);
        check("R9 refresh open bank", int'(last_ill), 1);

        step(3, 1, 1);
        check("R7 write beat", int'(wr_valid_o), 1);
        check("R7 write bank", int'(wr_bank_o), 1);
        step(0);
        step(1, 0);
        step(2, 0, 0);
        check("R6 cut write ap", dut_st(1), 4);
        step(0); step(0);
        check("R6 after twr", dut_st(1), 5);
        step(5, 1);
        check("R10 stop wrong bank", int'(last_ill), 1);
        step(5, 0);
        check("R10 stop ok", int'(last_ill), 0);
        check("R10 stop to active", dut_st(0), 1);
        step(1, 0);
        check("R11 act on active", int'(last_ill), 1);
        check("R12 no change", dut_st(0), 1);
        step(9, 2);
        check("R11 unused code", int'(last_ill), 1);
        step(4, 0);
        check("R13 precharge", dut_st(0), 5);
        nops(6);
        check("R13 idle", dut_st(0), 0);
        step(8);
        check("R9 mode all idle", int'(last_ill), 0);
        step(4, 2);
        check("R13 pre idle legal", int'(last_ill), 0);
        check("R13 pre idle no change", dut_st(2), 0);

        cl3_i = 1'b1;
        step(1, 2); step(1, 3); step(2, 2); step(0); step(2, 3);
        nops(8);

        for (int n = 0; n < 4000; n++) begin
            int r, c;
            if (n % 500 == 0) begin
                twr_i = 3'($urandom_range(0, 7));
                trp_i = 3'($urandom_range(0, 7));
                cl3_i = 1'($urandom_range(0, 1));
            end
            r = $urandom_range(0, 19);
            if (r < 6) c = 0;
            else if (r < 9) c = 1;
            else if (r < 12) c = 2;
            else if (r < 15) c = 3;
            else if (r < 16) c = 4;
            else if (r < 17) c = 5;
            else if (r < 19) c = $urandom_range(6, 8);
            else c = $urandom_range(9, 15);
            step(c, $urandom_range(0, 3), $urandom_range(0, 1));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule